// File: doc/BRIEF.md
# Mode-Split Translation Cache with Invalidation Controls

This block caches virtual-to-physical page translations for a processor that runs in two privilege levels. It keeps one direct-mapped entry array for user mode and a second, separate one for supervisor mode. A lookup names a mode and a virtual address. One cycle later the block answers with hit or miss and, on a hit, the physical frame number, a read-only flag and a cache-inhibit flag. A page walker outside the block supplies fill results, which are written into the array of the mode they belong to.

The address-decode logic around the block turns software actions into single-cycle command pulses. A read of the translation-control register flushes both arrays. A write of zero to that register flushes the user array, and a write of `0x8000` flushes the supervisor array. A load of either segment-table pointer flushes its own mode. A write in the purge address space removes the page of the addressed VA from both arrays at once. Every bulk flush takes effect in a single cycle, because it only clears a vector of valid bits.

Top module: `mode_tlb`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid` and `rsp_hit` are 0. Every lookup misses until a fill has been made.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid`. On a hit, `rsp_frame`, `rsp_ro` and `rsp_ci` carry the filled values. On a miss all three are 0.
- R3: The two modes are independent. `lk_sup`/`fill_sup` = 0 selects user and 1 selects supervisor. A fill in one mode is never seen by a lookup in the other, and the same VA can hold a different frame in each mode.
- R4: The array is direct-mapped. The index is VA bits [PAGE_BITS+IDX_W-1:PAGE_BITS] (bits 21:12 by default), and the tag is the VA bits above the index. The low PAGE_BITS offset bits play no part in matching. A fill to an occupied index replaces the old entry.
- R5: A cycle with `ctl_rd` = 1 invalidates every entry of both modes.
- R6: A cycle with `ctl_wr` = 1 and `ctl_wdata` = 0 invalidates only user entries. With `ctl_wdata` = `0x8000` it invalidates only supervisor entries. Any other value changes nothing.
- R7: `stp_user_ld` invalidates every user entry and `stp_sup_ld` invalidates every supervisor entry. The other mode keeps its entries.
- R8: A `purge_valid` cycle invalidates the entry whose page matches `purge_va` in both modes. Entries of other pages are kept.
- R9: A lookup sees the array as it was before the cycle's updates. When the same cycle carries a flush of the lookup's mode, or a purge of the lookup's page, the lookup misses. A fill made in the same cycle as a lookup is not seen by that lookup.
- R10: A fill and a purge of the same page in one cycle leave no entry for that page. A fill in the same cycle as a bulk flush of its mode leaves no entry either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_sup | input | 1 | Lookup mode (1 = supervisor) |
| lk_va | input | VA_W | Lookup virtual address |
| fill_valid | input | 1 | Write a walker result |
| fill_sup | input | 1 | Fill mode (1 = supervisor) |
| fill_va | input | VA_W | Fill virtual address |
| fill_frame | input | FRAME_W | Physical frame number to store |
| fill_ro | input | 1 | Read-only flag to store |
| fill_ci | input | 1 | Cache-inhibit flag to store |
| ctl_rd | input | 1 | Control-register read: flush both modes |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | CTL_W | Control-register write data |
| stp_user_ld | input | 1 | User segment-table pointer loaded |
| stp_sup_ld | input | 1 | Supervisor segment-table pointer loaded |
| purge_valid | input | 1 | Single-page purge request |
| purge_va | input | VA_W | Virtual address to purge |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | FRAME_W | Physical frame on hit, else 0 |
| rsp_ro | output | 1 | Read-only flag on hit, else 0 |
| rsp_ci | output | 1 | Cache-inhibit flag on hit, else 0 |

## Verification
A corrupted valid vector or tag store shows up as a wrong hit or miss on the first lookup of an affected index. That response appears one cycle after the lookup is issued. A flush or purge that reaches the wrong mode shows up as a stale hit in the mode that should have been cleared, or as a lost hit in the mode that should have been kept. For that reason each invalidation test probes both modes directly afterwards. Same-cycle conflicts are checked at the response of the very cycle that carries them, because a fault in the masking logic is only visible there.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } tlb_mode_e;

  localparam int unsigned NUM_MODES = 2;
endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tlb_cmd_decode.sv
module tlb_cmd_decode
  import tlb_pkg::*;
#(
  parameter int unsigned    CTL_W          = 32,
  parameter logic [CTL_W-1:0] SUP_FLUSH_CODE = CTL_W'(32'h0000_8000)
) (
  input  logic                 ctl_rd,
  input  logic                 ctl_wr,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 stp_user_ld,
  input  logic                 stp_sup_ld,
  output logic [NUM_MODES-1:0] flush_mode
);
  logic wr_user_code;
  logic wr_sup_code;

  always_comb begin
    wr_user_code = ctl_wr && (ctl_wdata == '0);
    wr_sup_code  = ctl_wr && (ctl_wdata == SUP_FLUSH_CODE);
    flush_mode   = '0;
    flush_mode[int'(MODE_USER)] = ctl_rd || wr_user_code || stp_user_ld;
    flush_mode[int'(MODE_SUP)]  = ctl_rd || wr_sup_code  || stp_sup_ld;
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned TAG_W   = 10,
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_ro,
  output logic               rd_ci,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_ro,
  input  logic               wr_ci,
  input  logic               purge_en,
  input  logic [IDX_W-1:0]   purge_idx,
  input  logic [TAG_W-1:0]   purge_tag
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]   valid_q;
  logic [DEPTH-1:0]   valid_d;
  logic               valid_en;
  logic [TAG_W-1:0]   tag_q   [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];
  logic [DEPTH-1:0]   ro_q;
  logic [DEPTH-1:0]   ci_q;

  logic wr_hits_purge_idx;
  logic purge_old;
  logic purge_new;
  logic purge_clr;

  // Purge of a stored entry is dropped when a fill overwrites that index
  // in the same cycle; a fill carrying the purged tag is itself cancelled.
  always_comb begin
    wr_hits_purge_idx = wr_en && (wr_idx == purge_idx);
    purge_old = purge_en && valid_q[purge_idx] &&
                (tag_q[purge_idx] == purge_tag) && !wr_hits_purge_idx;
    purge_new = purge_en && wr_hits_purge_idx && (wr_tag == purge_tag);
    purge_clr = purge_old || purge_new;
  end

  always_comb begin
    valid_d = valid_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
    if (purge_clr) begin
      valid_d[purge_idx] = 1'b0;
    end
    if (flush) begin
      valid_d = '0;
    end
    valid_en = wr_en || purge_clr || flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      frame_q[wr_idx] <= wr_frame;
      ro_q[wr_idx]    <= wr_ro;
      ci_q[wr_idx]    <= wr_ci;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_frame = frame_q[rd_idx];
    rd_ro    = ro_q[rd_idx];
    rd_ci    = ci_q[rd_idx];
  end
endmodule

// File: rtl/mode_tlb.sv
module mode_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned      VA_W           = 32,
  parameter int unsigned      PAGE_BITS      = 12,
  parameter int unsigned      IDX_W          = 10,
  parameter int unsigned      FRAME_W        = 20,
  parameter int unsigned      CTL_W          = 32,
  parameter logic [CTL_W-1:0] SUP_FLUSH_CODE = CTL_W'(32'h0000_8000),
  parameter int unsigned      RST_STAGES     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic               lk_sup,
  input  logic [VA_W-1:0]    lk_va,
  input  logic               fill_valid,
  input  logic               fill_sup,
  input  logic [VA_W-1:0]    fill_va,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_ro,
  input  logic               fill_ci,
  input  logic               ctl_rd,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               stp_user_ld,
  input  logic               stp_sup_ld,
  input  logic               purge_valid,
  input  logic [VA_W-1:0]    purge_va,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic               rsp_ro,
  output logic               rsp_ci
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned NMODE = NUM_MODES;

  logic rst_sync_n;

  tlb_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  logic [NMODE-1:0] flush_mode;

  tlb_cmd_decode #(
    .CTL_W          (CTL_W),
    .SUP_FLUSH_CODE (SUP_FLUSH_CODE)
  ) u_cmd (
    .ctl_rd      (ctl_rd),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (ctl_wdata),
    .stp_user_ld (stp_user_ld),
    .stp_sup_ld  (stp_sup_ld),
    .flush_mode  (flush_mode)
  );

  // Page-number split of each address port
  logic [VPN_W-1:0] lk_vpn, fill_vpn, purge_vpn;
  logic [IDX_W-1:0] lk_idx, fill_idx, purge_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag, purge_tag;

  always_comb begin
    lk_vpn    = lk_va[VA_W-1:PAGE_BITS];
    fill_vpn  = fill_va[VA_W-1:PAGE_BITS];
    purge_vpn = purge_va[VA_W-1:PAGE_BITS];
    lk_idx    = lk_vpn[IDX_W-1:0];
    fill_idx  = fill_vpn[IDX_W-1:0];
    purge_idx = purge_vpn[IDX_W-1:0];
    lk_tag    = lk_vpn[VPN_W-1:IDX_W];
    fill_tag  = fill_vpn[VPN_W-1:IDX_W];
    purge_tag = purge_vpn[VPN_W-1:IDX_W];
  end

  logic unused_offset_bits;
  assign unused_offset_bits = ^{lk_va[PAGE_BITS-1:0], fill_va[PAGE_BITS-1:0],
                                purge_va[PAGE_BITS-1:0]};

  logic [NMODE-1:0]   bank_valid;
  logic [NMODE-1:0]   bank_ro;
  logic [NMODE-1:0]   bank_ci;
  logic [TAG_W-1:0]   bank_tag   [NMODE];
  logic [FRAME_W-1:0] bank_frame [NMODE];

  for (genvar m = 0; m < NMODE; m++) begin : g_bank
    logic bank_wr_en;
    assign bank_wr_en = fill_valid && (fill_sup == 1'(m));

    tlb_bank #(
      .IDX_W   (IDX_W),
      .TAG_W   (TAG_W),
      .FRAME_W (FRAME_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .flush     (flush_mode[m]),
      .rd_idx    (lk_idx),
      .rd_valid  (bank_valid[m]),
      .rd_tag    (bank_tag[m]),
      .rd_frame  (bank_frame[m]),
      .rd_ro     (bank_ro[m]),
      .rd_ci     (bank_ci[m]),
      .wr_en     (bank_wr_en),
      .wr_idx    (fill_idx),
      .wr_tag    (fill_tag),
      .wr_frame  (fill_frame),
      .wr_ro     (fill_ro),
      .wr_ci     (fill_ci),
      .purge_en  (purge_valid),
      .purge_idx (purge_idx),
      .purge_tag (purge_tag)
    );
  end

  // Lookup evaluation on pre-update state, masked by same-cycle invalidation
  logic               purge_same_page;
  logic               hit_c;
  logic               rsp_valid_d, rsp_hit_d, rsp_ro_d, rsp_ci_d;
  logic [FRAME_W-1:0] rsp_frame_d;
  logic               rsp_en;
  logic               rsp_valid_q, rsp_hit_q, rsp_ro_q, rsp_ci_q;
  logic [FRAME_W-1:0] rsp_frame_q;

  always_comb begin
    purge_same_page = purge_valid && (purge_vpn == lk_vpn);
    hit_c = lk_valid && bank_valid[lk_sup] && (bank_tag[lk_sup] == lk_tag) &&
            !flush_mode[lk_sup] && !purge_same_page;
    rsp_valid_d = lk_valid;
    rsp_hit_d   = hit_c;
    rsp_frame_d = hit_c ? bank_frame[lk_sup] : '0;
    rsp_ro_d    = hit_c && bank_ro[lk_sup];
    rsp_ci_d    = hit_c && bank_ci[lk_sup];
    rsp_en      = lk_valid || rsp_valid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_frame_q <= '0;
      rsp_ro_q    <= 1'b0;
      rsp_ci_q    <= 1'b0;
    end else if (rsp_en) begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_frame_q <= rsp_frame_d;
      rsp_ro_q    <= rsp_ro_d;
      rsp_ci_q    <= rsp_ci_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_frame = rsp_frame_q;
  assign rsp_ro    = rsp_ro_q;
  assign rsp_ci    = rsp_ci_q;
endmodule

// File: rtl/mode_tlb_chk.sv
module mode_tlb_chk #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned FRAME_W    = 20,
  parameter int unsigned CTL_W      = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_sup,
  input logic [VA_W-1:0]    lk_va,
  input logic               fill_valid,
  input logic               fill_sup,
  input logic [VA_W-1:0]    fill_va,
  input logic [FRAME_W-1:0] fill_frame,
  input logic               ctl_rd,
  input logic               ctl_wr,
  input logic [CTL_W-1:0]   ctl_wdata,
  input logic               stp_user_ld,
  input logic               stp_sup_ld,
  input logic               purge_valid,
  input logic [VA_W-1:0]    purge_va,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [FRAME_W-1:0] rsp_frame
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;

  // Counts edges after reset release until the internal reset has settled
  logic [7:0] settle_q;
  logic       live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (settle_q < 8'(RST_STAGES)) begin
      settle_q <= settle_q + 8'd1;
    end
  end
  assign live = (settle_q >= 8'(RST_STAGES));

  logic no_cmd;
  assign no_cmd = !ctl_rd && !ctl_wr && !stp_user_ld && !stp_sup_ld && !purge_valid;

  logic [VPN_W-1:0] lk_page, purge_page, fill_page;
  assign lk_page    = lk_va[VA_W-1:PAGE_BITS];
  assign purge_page = purge_va[VA_W-1:PAGE_BITS];
  assign fill_page  = fill_va[VA_W-1:PAGE_BITS];

  logic unused_chk_bits;
  assign unused_chk_bits = ^{lk_va[PAGE_BITS-1:0], purge_va[PAGE_BITS-1:0],
                             fill_va[PAGE_BITS-1:0], ctl_wdata};

  // Record of a fill made in the previous cycle with no command alongside
  logic               f_vld_q;
  logic               f_sup_q;
  logic [VPN_W-1:0]   f_page_q;
  logic [FRAME_W-1:0] f_frame_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_vld_q   <= 1'b0;
      f_sup_q   <= 1'b0;
      f_page_q  <= '0;
      f_frame_q <= '0;
    end else begin
      f_vld_q   <= live && fill_valid && no_cmd;
      f_sup_q   <= fill_sup;
      f_page_q  <= fill_page;
      f_frame_q <= fill_frame;
    end
  end

  assert_rsp_follows_lk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && lk_valid) |=> rsp_valid);

  assert_idle_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_valid) |=> (!rsp_valid && !rsp_hit));

  assert_flush_all_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && lk_valid && ctl_rd) |=> !rsp_hit);

  assert_purge_page_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && lk_valid && purge_valid && (purge_page == lk_page)) |=> !rsp_hit);

  assert_fill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && f_vld_q && lk_valid && no_cmd && (lk_sup == f_sup_q) && (lk_page == f_page_q))
      |=> (rsp_hit && (rsp_frame == $past(f_frame_q))));
endmodule

bind mode_tlb mode_tlb_chk #(
  .VA_W       (VA_W),
  .PAGE_BITS  (PAGE_BITS),
  .FRAME_W    (FRAME_W),
  .CTL_W      (CTL_W),
  .RST_STAGES (RST_STAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_sup      (lk_sup),
  .lk_va       (lk_va),
  .fill_valid  (fill_valid),
  .fill_sup    (fill_sup),
  .fill_va     (fill_va),
  .fill_frame  (fill_frame),
  .ctl_rd      (ctl_rd),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .stp_user_ld (stp_user_ld),
  .stp_sup_ld  (stp_sup_ld),
  .purge_valid (purge_valid),
  .purge_va    (purge_va),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_frame   (rsp_frame)
);

// File: tb/tb_mode_tlb.sv
module tb_mode_tlb;
  logic        clk;
  logic        rst_n;
  logic        lk_valid, lk_sup;
  logic [31:0] lk_va;
  logic        fill_valid, fill_sup, fill_ro, fill_ci;
  logic [31:0] fill_va;
  logic [19:0] fill_frame;
  logic        ctl_rd, ctl_wr;
  logic [31:0] ctl_wdata;
  logic        stp_user_ld, stp_sup_ld;
  logic        purge_valid;
  logic [31:0] purge_va;
  logic        rsp_valid, rsp_hit, rsp_ro, rsp_ci;
  logic [19:0] rsp_frame;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Index = VA[21:12], tag = VA[31:22]
  localparam logic [31:0] VA_A  = 32'h0040_3000;  // idx 3, tag 1
  localparam logic [31:0] VA_A2 = 32'h0040_3ABC;  // same page as VA_A
  localparam logic [31:0] VA_B  = 32'h0080_3000;  // idx 3, tag 2
  localparam logic [31:0] VA_C  = 32'h0000_5000;  // idx 5, tag 0

  mode_tlb dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_sup(lk_sup), .lk_va(lk_va),
    .fill_valid(fill_valid), .fill_sup(fill_sup), .fill_va(fill_va),
    .fill_frame(fill_frame), .fill_ro(fill_ro), .fill_ci(fill_ci),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stp_user_ld(stp_user_ld), .stp_sup_ld(stp_sup_ld),
    .purge_valid(purge_valid), .purge_va(purge_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
    .rsp_ro(rsp_ro), .rsp_ci(rsp_ci)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic clr_in();
    lk_valid = 0; lk_sup = 0; lk_va = '0;
    fill_valid = 0; fill_sup = 0; fill_va = '0; fill_frame = '0; fill_ro = 0; fill_ci = 0;
    ctl_rd = 0; ctl_wr = 0; ctl_wdata = '0;
    stp_user_ld = 0; stp_sup_ld = 0; purge_valid = 0; purge_va = '0;
  endtask

  task automatic chk_rsp(input string req, input logic eh, input logic [19:0] ef,
                         input logic ero, input logic eci);
    n_checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_frame !== ef ||
        rsp_ro !== ero || rsp_ci !== eci) begin
      n_fail++;
      $display("FAIL %s: got v=%b hit=%b frame=%h ro=%b ci=%b, exp v=1 hit=%b frame=%h ro=%b ci=%b",
               req, rsp_valid, rsp_hit, rsp_frame, rsp_ro, rsp_ci, eh, ef, ero, eci);
    end
  endtask

  task automatic look(input string req, input logic sup, input logic [31:0] va,
                      input logic eh, input logic [19:0] ef, input logic ero, input logic eci);
    lk_valid = 1; lk_sup = sup; lk_va = va;
    @(negedge clk);
    lk_valid = 0;
    chk_rsp(req, eh, ef, ero, eci);
  endtask

  task automatic fill(input logic sup, input logic [31:0] va, input logic [19:0] fr,
                      input logic ro, input logic ci);
    fill_valid = 1; fill_sup = sup; fill_va = va; fill_frame = fr; fill_ro = ro; fill_ci = ci;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic t_reset();
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: after reset v=%b hit=%b, exp 0 0", rsp_valid, rsp_hit);
    end
    look("R1 user miss after reset", 0, VA_A, 0, '0, 0, 0);
    look("R1 sup miss after reset", 1, VA_C, 0, '0, 0, 0);
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: rsp_valid=%b with no lookup, exp 0", rsp_valid);
    end
  endtask

  task automatic t_fill_hit();
    fill(0, VA_A, 20'h12345, 1, 0);
    look("R2 user hit frame/ro", 0, VA_A, 1, 20'h12345, 1, 0);
    look("R4 offset ignored", 0, VA_A2, 1, 20'h12345, 1, 0);
    fill(0, VA_C, 20'h0ABCD, 0, 1);
    look("R2 user hit ci", 0, VA_C, 1, 20'h0ABCD, 0, 1);
  endtask

  task automatic t_modes();
    look("R3 sup miss on user entry", 1, VA_A, 0, '0, 0, 0);
    fill(1, VA_A, 20'h55555, 0, 0);
    look("R3 sup own frame", 1, VA_A, 1, 20'h55555, 0, 0);
    look("R3 user frame kept", 0, VA_A, 1, 20'h12345, 1, 0);
  endtask

  task automatic t_replace();
    fill(0, VA_B, 20'h00B0B, 0, 0);
    look("R4 replaced entry miss", 0, VA_A, 0, '0, 0, 0);
    look("R4 new entry hit", 0, VA_B, 1, 20'h00B0B, 0, 0);
  endtask

  task automatic load_both();
    fill(0, VA_A, 20'h11111, 0, 0);
    fill(1, VA_A, 20'h22222, 0, 0);
  endtask

  task automatic t_flush_all();
    load_both();
    ctl_rd = 1; @(negedge clk); ctl_rd = 0;
    look("R5 user flushed", 0, VA_A, 0, '0, 0, 0);
    look("R5 sup flushed", 1, VA_A, 0, '0, 0, 0);
  endtask

  task automatic t_ctl_wr();
    load_both();
    ctl_wr = 1; ctl_wdata = 32'h0000_1234; @(negedge clk); ctl_wr = 0;
    look("R6 other code user kept", 0, VA_A, 1, 20'h11111, 0, 0);
    look("R6 other code sup kept", 1, VA_A, 1, 20'h22222, 0, 0);
    ctl_wr = 1; ctl_wdata = 32'h0; @(negedge clk); ctl_wr = 0;
    look("R6 zero flushes user", 0, VA_A, 0, '0, 0, 0);
    look("R6 zero keeps sup", 1, VA_A, 1, 20'h22222, 0, 0);
    load_both();
    ctl_wr = 1; ctl_wdata = 32'h0000_8000; @(negedge clk); ctl_wr = 0;
    look("R6 8000 flushes sup", 1, VA_A, 0, '0, 0, 0);
    look("R6 8000 keeps user", 0, VA_A, 1, 20'h11111, 0, 0);
  endtask

  task automatic t_stp();
    load_both();
    stp_user_ld = 1; @(negedge clk); stp_user_ld = 0;
    look("R7 user ptr flushes user", 0, VA_A, 0, '0, 0, 0);
    look("R7 user ptr keeps sup", 1, VA_A, 1, 20'h22222, 0, 0);
    load_both();
    stp_sup_ld = 1; @(negedge clk); stp_sup_ld = 0;
    look("R7 sup ptr flushes sup", 1, VA_A, 0, '0, 0, 0);
    look("R7 sup ptr keeps user", 0, VA_A, 1, 20'h11111, 0, 0);
  endtask

  task automatic t_purge();
    load_both();
    fill(0, VA_C, 20'h33333, 0, 0);
    purge_valid = 1; purge_va = VA_A2; @(negedge clk); purge_valid = 0;
    look("R8 purge user", 0, VA_A, 0, '0, 0, 0);
    look("R8 purge sup", 1, VA_A, 0, '0, 0, 0);
    look("R8 other page kept", 0, VA_C, 1, 20'h33333, 0, 0);
  endtask

  task automatic t_same_cycle();
    load_both();
    ctl_rd = 1; look("R9 lookup with flush misses", 0, VA_A, 0, '0, 0, 0); ctl_rd = 0;
    load_both();
    purge_valid = 1; purge_va = VA_A;
    look("R9 lookup with purge misses", 1, VA_A, 0, '0, 0, 0);
    purge_valid = 0;
    fill_valid = 1; fill_sup = 0; fill_va = VA_B; fill_frame = 20'h44444;
    look("R9 fill not seen same cycle", 0, VA_B, 0, '0, 0, 0);
    fill_valid = 0;
    look("R9 fill seen next cycle", 0, VA_B, 1, 20'h44444, 0, 0);
  endtask

  task automatic t_conflict();
    fill_valid = 1; fill_sup = 1; fill_va = VA_C; fill_frame = 20'h66666;
    purge_valid = 1; purge_va = VA_C;
    @(negedge clk);
    fill_valid = 0; purge_valid = 0;
    look("R10 purge beats fill", 1, VA_C, 0, '0, 0, 0);
    fill_valid = 1; fill_sup = 0; fill_va = VA_C; fill_frame = 20'h77777;
    stp_user_ld = 1;
    @(negedge clk);
    fill_valid = 0; stp_user_ld = 0;
    look("R10 flush beats fill", 0, VA_C, 0, '0, 0, 0);
  endtask

  initial begin
    clr_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: in reset v=%b hit=%b, exp 0 0", rsp_valid, rsp_hit);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_hit();
    t_modes();
    t_replace();
    t_flush_all();
    t_ctl_wr();
    t_stp();
    t_purge();
    t_same_cycle();
    t_conflict();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule